// File: doc/BRIEF.md
# Sleep and Reset Sequencer

This block governs the power states and reset start-up of a small 8-bit controller core. It receives sleep requests from the CPU, a power-good indication, a watchdog expiry pulse, interrupt requests with their enables, and a set of keyboard row lines plus a host data line that can wake the part from its deepest sleep. From these it drives three controls: an enable for the CPU clock, an enable for the oscillator and a core reset.

A single counter provides the start-up delay. It is started both when power becomes good and when the part is woken from STOP by a falling edge on a wake line. An input lets the delay be skipped on such a wake. Two status flags let firmware learn why it restarted. The warm flag is set on STOP entry and cleared by a read strobe. The watchdog flag records a watchdog reset. One control bit decides whether the watchdog keeps counting in HALT.

All logic runs on a free-running clock that stands in for the oscillator. The clock enables it produces gate the CPU elsewhere.

Top module: `sleep_seq`

## Requirements
- R1: While `extRstN` is low, `coreRst`=1, `cpuClkEn`=0, `oscEn`=1, `wdtRun`=0, and `warmFlag`, `wdtFlag` and `wdtHaltOn` are 0.
- R2: While `pwrGood` is low, `coreRst` is 1 and both flags are 0. At the first clock edge that sees `pwrGood` high, the start-up delay begins. `coreRst` then stays 1 for exactly POR_CYCLES cycles and falls on the following edge, which is edge POR_CYCLES+1 counted from that first edge.
- R3: In the running state, `coreRst`=0, `cpuClkEn`=1, `oscEn`=1.
- R4: `haltReq` sampled high while running enters HALT at that edge. HALT gives `cpuClkEn`=0 and `oscEn`=1.
- R5: HALT is left for the running state at the edge where any bit of `irqReq & irqEn` is 1. Requests whose enable bit is 0 have no effect.
- R6: `stopReq` sampled high while running enters STOP and takes priority over `haltReq`. STOP gives `cpuClkEn`=0 and `oscEn`=0. Interrupt requests do not leave STOP.
- R7: In STOP, a wake event leaves STOP. A wake event is a line of `wakeRows` or `hostData` that was high at the previous edge and is low at this one, so a low pulse lasting one cycle is enough. A line held low does not wake. With `bypassOnWake`=0, `coreRst` is 1 from the wake edge for POR_CYCLES cycles and then falls.
- R8: `wdtRun` is 1 in the running state. In HALT it equals `wdtHaltOn`. It is 0 in STOP and while `coreRst` is 1.
- R9: `warmFlag` becomes 1 at STOP entry. It is 0 after a power-good or watchdog reset. It clears at the edge that samples `statusRd` high.
- R10: `wdtHaltOn` loads `ctlWdata` at an edge where `ctlWe` is 1. It is forced to 0 at every edge where `coreRst` is 1.
- R11: With `bypassOnWake`=1, a wake event gives `coreRst`=1 for one cycle only, after which the block is running.
- R12: `wdtTimeout` outside power-off takes priority over every request. It gives `coreRst`=1 for one cycle and then running. It sets `wdtFlag`, which stays 1 until power is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running always-on clock |
| extRstN | input | 1 | Asynchronous external reset, active low |
| pwrGood | input | 1 | Supply good indication |
| haltReq | input | 1 | CPU request to enter HALT |
| stopReq | input | 1 | CPU request to enter STOP |
| irqReq | input | IRQ_W | Interrupt request lines |
| irqEn | input | IRQ_W | Per-line interrupt enables |
| wdtTimeout | input | 1 | Watchdog expiry pulse |
| wakeRows | input | ROW_W | Keyboard row lines used for wake |
| hostData | input | 1 | Host data line used for wake |
| bypassOnWake | input | 1 | Skip start-up delay on wake from STOP |
| statusRd | input | 1 | Read strobe that clears the warm flag |
| ctlWe | input | 1 | Write strobe for the watchdog-in-HALT bit |
| ctlWdata | input | 1 | Value written to the watchdog-in-HALT bit |
| cpuClkEn | output | 1 | CPU clock enable |
| oscEn | output | 1 | Oscillator enable |
| coreRst | output | 1 | Core reset, active high |
| wdtRun | output | 1 | Watchdog counting enable |
| warmFlag | output | 1 | 1 when the last restart was a wake from STOP |
| wdtFlag | output | 1 | 1 when the last reset came from the watchdog |
| wdtHaltOn | output | 1 | Watchdog-in-HALT control bit |

## Verification
The hardest situation to reach is a wake from STOP caused by a single-cycle low pulse. It has to be checked together with its opposite case, a wake line that is already low when STOP is entered and must not cause a wake. To reach both, the stimulus first enters STOP, raises interrupts that must be ignored, and then pulses a row line low for exactly one cycle. Later it holds a row line low across STOP entry and only then releases it and pulls it low again. Each wake is followed cycle by cycle through the full delay, and also through the bypass path.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_DELAY,
    ST_KICK,
    ST_RUN,
    ST_HALT,
    ST_STOP
  } seqState_t;

  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic warmSet;
    logic warmClr;
    logic wdtSet;
    logic wdtClr;
  } seqStrobe_t;

endpackage

// File: rtl/sleep_seq_wake.sv
module sleep_seq_wake #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] pins,
  output logic         anyFall
);

  logic [N-1:0] lastQ;
  logic [N-1:0] fallVec;

  for (genvar i = 0; i < N; i++) begin : g_edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) lastQ[i] <= 1'b1;
      else       lastQ[i] <= pins[i];
    end
    assign fallVec[i] = lastQ[i] & ~pins[i];
  end

  assign anyFall = |fallVec;

  // R7: a line held low for two edges cannot report a new edge
  assert_no_level_wake_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pins == {N{1'b0}} && lastQ == {N{1'b0}}) |-> !anyFall);

endmodule

// File: rtl/sleep_seq_dp.sv
module sleep_seq_dp
  import sleep_seq_pkg::*;
#(
  parameter int POR_CYCLES = 589824
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strb,
  input  logic       statusRd,
  input  logic       ctlWe,
  input  logic       ctlWdata,
  input  logic       coreRst,
  output logic       cntDone,
  output logic       warmFlag,
  output logic       wdtFlag,
  output logic       wdtHaltOn
);

  localparam int CNT_W = $clog2(POR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POR_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strb.cntClr) cnt <= '0;
    else if (strb.cntInc && cnt != CNT_LAST) cnt <= cnt + 1'b1;
  end

  assign cntDone = (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warmFlag <= 1'b0;
    else if (strb.warmClr)  warmFlag <= 1'b0;
    else if (strb.warmSet)  warmFlag <= 1'b1;
    else if (statusRd)      warmFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wdtFlag <= 1'b0;
    else if (strb.wdtClr)  wdtFlag <= 1'b0;
    else if (strb.wdtSet)  wdtFlag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        wdtHaltOn <= 1'b0;
    else if (coreRst) wdtHaltOn <= 1'b0;
    else if (ctlWe)   wdtHaltOn <= ctlWdata;
  end

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_LAST);

  assert_warm_set_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.warmSet && !strb.warmClr) |=> warmFlag);

  assert_warm_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !strb.warmSet) |=> !warmFlag);

  assert_ctl_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    coreRst |=> !wdtHaltOn);

endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrGood,
  input  logic       haltReq,
  input  logic       stopReq,
  input  logic       irqHit,
  input  logic       wdtTimeout,
  input  logic       wakeEvt,
  input  logic       bypassOnWake,
  input  logic       cntDone,
  input  logic       wdtHaltOn,
  output seqStrobe_t strb,
  output logic       coreRst,
  output logic       cpuClkEn,
  output logic       oscEn,
  output logic       wdtRun
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    if (!pwrGood) begin
      stateNext    = ST_OFF;
      strb.cntClr  = 1'b1;
      strb.warmClr = 1'b1;
      strb.wdtClr  = 1'b1;
    end else if (state == ST_OFF) begin
      stateNext   = ST_DELAY;
      strb.cntClr = 1'b1;
    end else if (wdtTimeout) begin
      stateNext    = ST_KICK;
      strb.wdtSet  = 1'b1;
      strb.warmClr = 1'b1;
    end else begin
      unique case (state)
        ST_DELAY: begin
          strb.cntInc = 1'b1;
          if (cntDone) stateNext = ST_RUN;
        end
        ST_KICK: stateNext = ST_RUN;
        ST_RUN: begin
          if (stopReq) begin
            stateNext    = ST_STOP;
            strb.warmSet = 1'b1;
          end else if (haltReq) begin
            stateNext = ST_HALT;
          end
        end
        ST_HALT: if (irqHit) stateNext = ST_RUN;
        ST_STOP: begin
          if (wakeEvt) begin
            if (bypassOnWake) begin
              stateNext = ST_KICK;
            end else begin
              stateNext   = ST_DELAY;
              strb.cntClr = 1'b1;
            end
          end
        end
        default: stateNext = ST_OFF;
      endcase
    end
  end

  assign coreRst  = (state == ST_OFF) || (state == ST_DELAY) || (state == ST_KICK);
  assign cpuClkEn = (state == ST_RUN);
  assign oscEn    = (state != ST_STOP);
  assign wdtRun   = (state == ST_RUN) || ((state == ST_HALT) && wdtHaltOn);

  assert_pwr_loss_R2: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> coreRst);

  assert_halt_enter_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && pwrGood && !wdtTimeout && haltReq && !stopReq)
      |=> (state == ST_HALT));

  assert_stop_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && pwrGood && !wdtTimeout && !wakeEvt)
      |=> (!cpuClkEn && !oscEn));

  assert_wdt_kick_R12: assert property (@(posedge clk) disable iff (!rstN)
    (pwrGood && wdtTimeout && state != ST_OFF) |=> (coreRst && state == ST_KICK));

  assert_kick_short_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_KICK && pwrGood && !wdtTimeout) |=> !coreRst);

endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int POR_CYCLES = 589824,
  parameter int IRQ_W      = 5,
  parameter int ROW_W      = 7
) (
  input  logic             clk,
  input  logic             extRstN,
  input  logic             pwrGood,
  input  logic             haltReq,
  input  logic             stopReq,
  input  logic [IRQ_W-1:0] irqReq,
  input  logic [IRQ_W-1:0] irqEn,
  input  logic             wdtTimeout,
  input  logic [ROW_W-1:0] wakeRows,
  input  logic             hostData,
  input  logic             bypassOnWake,
  input  logic             statusRd,
  input  logic             ctlWe,
  input  logic             ctlWdata,
  output logic             cpuClkEn,
  output logic             oscEn,
  output logic             coreRst,
  output logic             wdtRun,
  output logic             warmFlag,
  output logic             wdtFlag,
  output logic             wdtHaltOn
);

  localparam int WAKE_W = ROW_W + 1;

  seqStrobe_t strb;
  logic       cntDone;
  logic       wakeEvt;
  logic       irqHit;

  assign irqHit = |(irqReq & irqEn);

  sleep_seq_wake #(.N(WAKE_W)) wake_i (
    .clk     (clk),
    .rstN    (extRstN),
    .pins    ({hostData, wakeRows}),
    .anyFall (wakeEvt)
  );

  sleep_seq_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (extRstN),
    .pwrGood      (pwrGood),
    .haltReq      (haltReq),
    .stopReq      (stopReq),
    .irqHit       (irqHit),
    .wdtTimeout   (wdtTimeout),
    .wakeEvt      (wakeEvt),
    .bypassOnWake (bypassOnWake),
    .cntDone      (cntDone),
    .wdtHaltOn    (wdtHaltOn),
    .strb         (strb),
    .coreRst      (coreRst),
    .cpuClkEn     (cpuClkEn),
    .oscEn        (oscEn),
    .wdtRun       (wdtRun)
  );

  sleep_seq_dp #(.POR_CYCLES(POR_CYCLES)) dp_i (
    .clk       (clk),
    .rstN      (extRstN),
    .strb      (strb),
    .statusRd  (statusRd),
    .ctlWe     (ctlWe),
    .ctlWdata  (ctlWdata),
    .coreRst   (coreRst),
    .cntDone   (cntDone),
    .warmFlag  (warmFlag),
    .wdtFlag   (wdtFlag),
    .wdtHaltOn (wdtHaltOn)
  );

endmodule

// File: tb/sleep_seq_tb_top.sv
module sleep_seq_tb_top;

  localparam int CLK_P = 10;
  localparam int POR   = 16;
  localparam int IRQ_W = 5;
  localparam int ROW_W = 7;

  // observed vector bits: [5]coreRst [4]cpuClkEn [3]oscEn [2]wdtRun [1]warmFlag [0]wdtFlag
  localparam logic [5:0] V_OFF  = 6'b101000;
  localparam logic [5:0] V_RUN  = 6'b011100;
  localparam logic [5:0] V_HALT = 6'b001000;
  localparam logic [5:0] V_STOP = 6'b000000;

  typedef struct {
    string      tag;
    logic [5:0] exp;
  } sbItem_t;

  logic clk = 1'b0;
  logic extRstN, pwrGood, haltReq, stopReq, wdtTimeout, hostData;
  logic bypassOnWake, statusRd, ctlWe, ctlWdata;
  logic [IRQ_W-1:0] irqReq, irqEn;
  logic [ROW_W-1:0] wakeRows;
  logic cpuClkEn, oscEn, coreRst, wdtRun, warmFlag, wdtFlag, wdtHaltOn;

  sbItem_t sbQ[$];
  int      checks = 0;
  int      errors = 0;
  bit      finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sleep_seq #(.POR_CYCLES(POR), .IRQ_W(IRQ_W), .ROW_W(ROW_W)) dut_i (
    .clk, .extRstN, .pwrGood, .haltReq, .stopReq, .irqReq, .irqEn,
    .wdtTimeout, .wakeRows, .hostData, .bypassOnWake, .statusRd,
    .ctlWe, .ctlWdata, .cpuClkEn, .oscEn, .coreRst, .wdtRun,
    .warmFlag, .wdtFlag, .wdtHaltOn
  );

  // monitor: compares one queued expectation a quarter period after each edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sbQ.size() > 0) begin
        sbItem_t it;
        logic [5:0] obs;
        it  = sbQ.pop_front();
        obs = {coreRst, cpuClkEn, oscEn, wdtRun, warmFlag, wdtFlag};
        checks++;
        if (obs !== it.exp) begin
          errors++;
          $display("FAIL %s: got %b expected %b", it.tag, obs, it.exp);
        end
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog: got hung run expected completion");
    finishRun();
  end

  // driver: wait one edge, queue the expected outputs after it
  task automatic step(string tag, logic [5:0] exp);
    @(posedge clk);
    sbQ.push_back('{tag, exp});
  endtask

  task automatic setup();
    @(negedge clk);
  endtask

  task automatic delayRun(string tag, logic [5:0] flags);
    for (int k = 0; k < POR - 1; k++) step(tag, V_OFF | flags);
  endtask

  initial begin
    extRstN = 0; pwrGood = 0; haltReq = 0; stopReq = 0; wdtTimeout = 0;
    hostData = 1; bypassOnWake = 0; statusRd = 0; ctlWe = 0; ctlWdata = 0;
    irqReq = '0; irqEn = '0; wakeRows = '1;

    step("R1 reset state", V_OFF);
    if (wdtHaltOn !== 1'b0) begin errors++; $display("FAIL R1: wdtHaltOn got %b expected 0", wdtHaltOn); end
    checks++;

    // R2 power-up delay
    setup(); extRstN = 1; pwrGood = 1;
    step("R2 delay start", V_OFF);
    delayRun("R2 delay hold", 6'b0);
    step("R3 running after delay", V_RUN);

    // R4 / R5 halt and wake by interrupt
    setup(); haltReq = 1;
    step("R4 halt entry", V_HALT);
    setup(); haltReq = 0; irqReq = 5'b00100; irqEn = 5'b11011;
    step("R5 masked irq ignored", V_HALT);
    setup(); irqEn = 5'b00100;
    step("R5 enabled irq exits halt", V_RUN);
    setup(); irqReq = '0;

    // R10 / R8 watchdog-in-halt bit
    ctlWe = 1; ctlWdata = 1;
    step("R10 write ctl bit", V_RUN);
    setup(); ctlWe = 0; haltReq = 1;
    step("R8 wdt runs in halt", V_HALT | 6'b000100);
    setup(); haltReq = 0; irqReq = 5'b00100;
    step("R5 exit halt", V_RUN);
    setup(); irqReq = '0;

    // R6 / R9 stop entry, stop has priority over halt
    stopReq = 1; haltReq = 1;
    step("R6 stop entry", V_STOP | 6'b000010);
    setup(); stopReq = 0; haltReq = 0; irqReq = 5'b11111; irqEn = 5'b11111;
    step("R6 irq ignored in stop", V_STOP | 6'b000010);
    // R7 single-cycle low pulse on a row wakes, full delay
    setup(); irqReq = '0; wakeRows[3] = 1'b0;
    step("R7 wake pulse", V_OFF | 6'b000010);
    setup(); wakeRows[3] = 1'b1;
    delayRun("R7 delay after wake", 6'b000010);
    step("R7 running after wake", V_RUN | 6'b000010);

    // R10 ctl bit cleared by reset
    setup(); haltReq = 1;
    step("R10 ctl cleared by reset", V_HALT | 6'b000010);
    setup(); haltReq = 0; irqReq = 5'b00001;
    step("R5 exit halt", V_RUN | 6'b000010);
    setup(); irqReq = '0;

    // R9 read clear
    statusRd = 1;
    step("R9 read clears warm", V_RUN);
    setup(); statusRd = 0;
    step("R9 warm stays clear", V_RUN);

    // R11 bypass via host data line
    setup(); bypassOnWake = 1; stopReq = 1;
    step("R11 stop entry", V_STOP | 6'b000010);
    setup(); stopReq = 0; hostData = 0;
    step("R11 short reset", V_OFF | 6'b000010);
    setup(); hostData = 1;
    step("R11 running", V_RUN | 6'b000010);

    // R12 watchdog reset
    setup(); wdtTimeout = 1; haltReq = 1;
    step("R12 wdt reset", V_OFF | 6'b000001);
    setup(); wdtTimeout = 0; haltReq = 0;
    step("R12 running with flag", V_RUN | 6'b000001);

    // R7 line held low across stop entry does not wake
    setup(); wakeRows[0] = 1'b0;
    step("R7 row low while running", V_RUN | 6'b000001);
    setup(); stopReq = 1;
    step("R7 stop entry", V_STOP | 6'b000011);
    setup(); stopReq = 0;
    step("R7 held low no wake", V_STOP | 6'b000011);
    setup(); wakeRows[0] = 1'b1;
    step("R7 rising no wake", V_STOP | 6'b000011);
    setup(); wakeRows[0] = 1'b0;
    step("R11 wake after release", V_OFF | 6'b000011);
    setup(); wakeRows[0] = 1'b1; bypassOnWake = 0;
    step("R12 flag kept", V_RUN | 6'b000011);

    // R2 power loss
    setup(); pwrGood = 0;
    step("R2 power lost", V_OFF);
    step("R2 held off", V_OFF);
    setup(); pwrGood = 1;
    step("R2 restart", V_OFF);
    delayRun("R2 restart delay", 6'b0);
    step("R2 running", V_RUN);

    repeat (3) @(posedge clk);
    finishRun();
  end

endmodule